// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Subset Core

This block is a small 32-bit processor core that completes every instruction in one clock. In that clock it fetches the word at the program counter, decodes it, reads two source registers, runs the ALU, optionally touches data memory, writes a result register, and selects the next program counter. It supports register-register arithmetic and logic, a signed set-less-than in register and immediate forms, word load and store, a conditional branch on equality, an absolute jump, and a linking jump that saves the return address for subroutine calls.

Instruction and data storage are word arrays inside the core. The environment fills them through a load port, normally while reset is held. Each retirement is shown on two commit ports. The writeback port gives the register number and value written this cycle. The store port gives the address and data of a store this cycle. The program counter is also an output, so all architectural effects can be seen from outside.

The decoder sorts each opcode into an instruction class. The classes are nop, ralu, slti, load, store, branch, jump and link. A unique case on the class then produces the control word. There is no multi-cycle state. The only sequential elements are the program counter, the register file and the two memories.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high the program counter is 0 and both commit enables are low, so no register or data-memory write occurs. On the first rising edge after `rst` falls, execution starts at address 0.
- R2: Opcode 0x00 with funct 0x20 (add), 0x22 (sub), 0x24 (and) or 0x25 (or) writes `rs op rt` into `rd`. Here rs is bits [25:21], rt is bits [20:16] and rd is bits [15:11]. An opcode 0x00 word with any other funct writes nothing.
- R3: Opcode 0x00 with funct 0x2A writes 1 to rd when rs is less than rt as signed 32-bit numbers, and 0 otherwise. The result is correct even when `rs - rt` overflows.
- R4: Opcode 0x0A writes 1 to rt (bits [20:16]) when rs is signed-less-than the sign-extended 16-bit immediate in bits [15:0], and 0 otherwise.
- R5: Opcode 0x23 loads the data word at `rs + sext(imm)` into rt. Opcode 0x2B stores rt to that address and reports the address and data on the store port in the same cycle. The word index into data memory is address bits [MEM_AW+1:2].
- R6: Opcode 0x04 compares rs and rt. If they are equal, the next PC is `PC+4 + (sext(imm) << 2)`. Otherwise the next PC is `PC+4`. With both operands set to register 0, this acts as an unconditional PC-relative branch.
- R7: Opcode 0x02 sets the next PC to `{(PC+4)[31:28], instr[25:0], 2'b00}`.
- R8: Opcode 0x03 writes PC+4 into register 31 and sets the next PC to the same jump target as R7, both in the same cycle.
- R9: Register 0 always reads as zero. A write aimed at it is dropped, and the writeback enable stays low for that instruction.
- R10: All other instructions, including undefined opcodes, advance the PC by 4. Every instruction retires in exactly one cycle, and the PC stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_en | input | 1 | Write `load_data` into a memory at the next edge |
| load_to_dmem | input | 1 | 1 selects data memory, 0 selects instruction memory |
| load_addr | input | MEM_AW | Word index for the load port |
| load_data | input | 32 | Word to preload |
| pc_o | output | 32 | Current program counter |
| wb_en_o | output | 1 | A register write retires this cycle |
| wb_addr_o | output | 5 | Register being written |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | A store retires this cycle |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Stored word |

## Verification
The linking jump is the case where two effects land in one cycle. It writes register 31 and redirects the program counter on the same edge. The program places a jal in the middle of straight-line code and then takes a plain jump from the target, so a wrong link value, a missed redirect or a lost write all show up. The bench compares the writeback port in the jal cycle and the program counter in the following cycle against its behavioural model. The same model also covers a register written by a store's neighbour and then read by a signed comparison whose subtraction overflows.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT} alu_op_e;

    typedef enum logic [2:0] {
        IC_NOP, IC_RALU, IC_SLTI, IC_LOAD, IC_STORE, IC_BRANCH, IC_JUMP, IC_LINK
    } iclass_e;

    typedef struct packed {
        logic    reg_dst;
        logic    alu_imm;
        logic    mem_to_reg;
        logic    reg_write;
        logic    mem_write;
        logic    branch;
        logic    jump;
        logic    link;
        alu_op_e alu_op;
    } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctrl_t      ctl
);
    iclass_e cls;
    alu_op_e r_op;

    always_comb begin
        r_op = ALU_ADD;
        cls  = IC_NOP;
        unique case (opcode)
            OP_RTYPE: begin
                cls = IC_RALU;
                unique case (funct)
                    FN_ADD:  r_op = ALU_ADD;
                    FN_SUB:  r_op = ALU_SUB;
                    FN_AND:  r_op = ALU_AND;
                    FN_OR:   r_op = ALU_OR;
                    FN_SLT:  r_op = ALU_SLT;
                    default: cls  = IC_NOP;
                endcase
            end
            OP_SLTI: cls = IC_SLTI;
            OP_LW:   cls = IC_LOAD;
            OP_SW:   cls = IC_STORE;
            OP_BEQ:  cls = IC_BRANCH;
            OP_J:    cls = IC_JUMP;
            OP_JAL:  cls = IC_LINK;
            default: cls = IC_NOP;
        endcase
    end

    always_comb begin
        ctl = '0;
        ctl.alu_op = ALU_ADD;
        unique case (cls)
            IC_RALU: begin
                ctl.reg_dst   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_op    = r_op;
            end
            IC_SLTI: begin
                ctl.alu_imm   = 1'b1;
                ctl.reg_write = 1'b1;
                ctl.alu_op    = ALU_SLT;
            end
            IC_LOAD: begin
                ctl.alu_imm    = 1'b1;
                ctl.mem_to_reg = 1'b1;
                ctl.reg_write  = 1'b1;
            end
            IC_STORE: begin
                ctl.alu_imm   = 1'b1;
                ctl.mem_write = 1'b1;
            end
            IC_BRANCH: begin
                ctl.branch = 1'b1;
                ctl.alu_op = ALU_SUB;
            end
            IC_JUMP: ctl.jump = 1'b1;
            IC_LINK: begin
                ctl.jump      = 1'b1;
                ctl.link      = 1'b1;
                ctl.reg_write = 1'b1;
            end
            default: ctl = '0;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y,
    output logic         zero
);
    logic [W-1:0] sum;
    logic [W-1:0] dif;
    logic         lt;

    assign sum = a + b;
    assign dif = a - b;
    // Signs differ: the negative operand is smaller; otherwise the difference cannot overflow.
    assign lt  = (a[W-1] != b[W-1]) ? a[W-1] : dif[W-1];

    always_comb begin
        unique case (op)
            ALU_ADD: y = sum;
            ALU_SUB: y = dif;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_SLT: y = {{(W-1){1'b0}}, lt};
            default: y = sum;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2
);
    logic [W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (we && waddr != '0) regs[waddr] <= wdata;
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6,
    localparam int MEM_WORDS = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic              load_to_dmem,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [31:0]       load_data,
    output logic [31:0]       pc_o,
    output logic              wb_en_o,
    output logic [4:0]        wb_addr_o,
    output logic [31:0]       wb_data_o,
    output logic              st_en_o,
    output logic [31:0]       st_addr_o,
    output logic [31:0]       st_data_o
);
    localparam logic [4:0] LINK_REG = 5'd31;

    logic [31:0] imem [MEM_WORDS];
    logic [31:0] dmem [MEM_WORDS];

    logic [31:0] pc_q, pc_next, pc_plus4, br_target, j_target, seq_or_br;
    logic [31:0] instr, sext, rd1, rd2, alu_b, alu_y, load_word;
    logic        alu_zero, taken;
    ctrl_t       ctl;

    assign instr = imem[pc_q[MEM_AW+1:2]];

    always_ff @(posedge clk) begin
        if (load_en && !load_to_dmem) imem[load_addr] <= load_data;
    end

    sc_decode u_dec (.opcode(instr[31:26]), .funct(instr[5:0]), .ctl(ctl));

    sc_regfile #(.NREG(32), .W(XLEN)) u_rf (
        .clk(clk), .we(wb_en_o), .waddr(wb_addr_o), .wdata(wb_data_o),
        .ra1(instr[25:21]), .ra2(instr[20:16]), .rd1(rd1), .rd2(rd2)
    );

    assign sext  = {{16{instr[15]}}, instr[15:0]};
    assign alu_b = ctl.alu_imm ? sext : rd2;

    sc_alu #(.W(XLEN)) u_alu (.a(rd1), .b(alu_b), .op(ctl.alu_op), .y(alu_y), .zero(alu_zero));

    always_ff @(posedge clk) begin
        if (load_en && load_to_dmem) dmem[load_addr] <= load_data;
        else if (st_en_o)            dmem[alu_y[MEM_AW+1:2]] <= rd2;
    end
    assign load_word = dmem[alu_y[MEM_AW+1:2]];

    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + (sext << 2);
    assign j_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
    assign taken     = ctl.branch & alu_zero;
    assign seq_or_br = taken ? br_target : pc_plus4;
    assign pc_next   = ctl.jump ? j_target : seq_or_br;

    always_ff @(posedge clk) begin
        if (rst) pc_q <= '0;
        else     pc_q <= pc_next;
    end

    assign wb_addr_o = ctl.link ? LINK_REG : (ctl.reg_dst ? instr[15:11] : instr[20:16]);
    assign wb_data_o = ctl.link ? pc_plus4 : (ctl.mem_to_reg ? load_word : alu_y);
    assign wb_en_o   = ctl.reg_write & !rst & (wb_addr_o != 5'd0);
    assign st_en_o   = ctl.mem_write & !rst;
    assign st_addr_o = alu_y;
    assign st_data_o = rd2;
    assign pc_o      = pc_q;

    assert_seq_pc_R10: assert property (@(posedge clk) disable iff (rst)
        (!ctl.jump && !taken) |=> (pc_q == $past(pc_q) + 32'd4));
    assert_pc_aligned_R10: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);
    assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
        ctl.jump |=> (pc_q == {$past(pc_plus4[31:28]), $past(instr[25:0]), 2'b00}));
    assert_link_write_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.link |-> (wb_en_o && wb_addr_o == 5'd31 && wb_data_o == pc_q + 32'd4));
    assert_slt_boolean_R3: assert property (@(posedge clk) disable iff (rst)
        (ctl.alu_op == ALU_SLT) |-> (alu_y[31:1] == 31'd0));
    assert_branch_taken_R6: assert property (@(posedge clk) disable iff (rst)
        (ctl.branch && rd1 == rd2) |=> (pc_q == $past(pc_plus4) + ($past(sext) << 2)));
endmodule

// File: tb/tb_sc_core.sv
module tb_sc_core;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 6;
    localparam int WORDS = 1 << AW;
    localparam int RUN_CYCLES = 48;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load_en = 1'b0;
    logic          load_to_dmem = 1'b0;
    logic [AW-1:0] load_addr = '0;
    logic [31:0]   load_data = '0;
    logic [31:0]   pc_o, wb_data_o, st_addr_o, st_data_o;
    logic [4:0]    wb_addr_o;
    logic          wb_en_o, st_en_o;

    int n_checks = 0;
    int n_fail   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_core #(.MEM_AW(AW)) dut (
        .clk(clk), .rst(rst), .load_en(load_en), .load_to_dmem(load_to_dmem),
        .load_addr(load_addr), .load_data(load_data), .pc_o(pc_o),
        .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;
    string       prev_tag;

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_j(logic [5:0] op, int tgt);
        return {op, tgt[25:0]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic load_word(input bit to_d, input int idx, input logic [31:0] val);
        @(negedge clk);
        load_en = 1'b1; load_to_dmem = to_d; load_addr = idx[AW-1:0]; load_data = val;
    endtask

    // Behavioural model: compare current outputs, then advance one instruction.
    task automatic compare_and_step();
        logic [31:0] ins, a, b, simm, val, addr, npc, pc4;
        logic [5:0]  op, fn;
        int          rs, rt, rd, dest;
        bit          wr, st;
        string       tag;
        ins  = m_imem[m_pc[AW+1:2]];
        op   = ins[31:26]; fn = ins[5:0];
        rs   = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a    = (rs == 0) ? 32'd0 : m_reg[rs];
        b    = (rt == 0) ? 32'd0 : m_reg[rt];
        simm = {{16{ins[15]}}, ins[15:0]};
        pc4  = m_pc + 32'd4;
        npc  = pc4; wr = 0; st = 0; dest = 0; val = '0; addr = '0; tag = "R10";
        case (op)
            6'h00: begin
                dest = rd; wr = 1; tag = "R2";
                case (fn)
                    6'h20: val = a + b;
                    6'h22: val = a - b;
                    6'h24: val = a & b;
                    6'h25: val = a | b;
                    6'h2A: begin val = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R3"; end
                    default: begin wr = 0; tag = "R2"; end
                endcase
            end
            6'h0A: begin dest = rt; wr = 1; tag = "R4";
                         val = ($signed(a) < $signed(simm)) ? 32'd1 : 32'd0; end
            6'h23: begin dest = rt; wr = 1; tag = "R5";
                         addr = a + simm; val = m_dmem[addr[AW+1:2]]; end
            6'h2B: begin st = 1; tag = "R5"; addr = a + simm; val = b; end
            6'h04: begin tag = "R6"; if (a == b) npc = pc4 + (simm << 2); end
            6'h02: begin tag = "R7"; npc = {pc4[31:28], ins[25:0], 2'b00}; end
            6'h03: begin tag = "R8"; dest = 31; wr = 1; val = pc4;
                         npc = {pc4[31:28], ins[25:0], 2'b00}; end
            default: tag = "R10";
        endcase
        if (wr && dest == 0) begin wr = 0; tag = "R9"; end

        check(pc_o === m_pc, prev_tag, "pc", pc_o, m_pc);
        check(wb_en_o === wr, tag, "wb_en", {31'd0, wb_en_o}, {31'd0, wr});
        if (wr) begin
            check(wb_addr_o === dest[4:0], tag, "wb_addr", {27'd0, wb_addr_o}, dest);
            check(wb_data_o === val, tag, "wb_data", wb_data_o, val);
        end
        check(st_en_o === st, tag, "st_en", {31'd0, st_en_o}, {31'd0, st});
        if (st) begin
            check(st_addr_o === addr, tag, "st_addr", st_addr_o, addr);
            check(st_data_o === val, tag, "st_data", st_data_o, val);
        end

        if (wr) m_reg[dest] = val;
        if (st) m_dmem[addr[AW+1:2]] = val;
        m_pc = npc;
        prev_tag = tag;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL R10 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < WORDS; i++) begin m_imem[i] = '0; m_dmem[i] = '0; end
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_imem[0]  = enc_i(6'h0A, 0, 1, 5);          // r1 = 1 (0 < 5)
        m_imem[1]  = enc_i(6'h0A, 0, 2, -3);         // r2 = 0 (0 < -3 false)
        m_imem[2]  = enc_i(6'h23, 0, 1, 12);         // r1 = dmem[3] = 5
        m_imem[3]  = enc_i(6'h23, 0, 2, 16);         // r2 = dmem[4] = -3
        m_imem[4]  = enc_r(1, 2, 3, 6'h20);          // add
        m_imem[5]  = enc_r(2, 1, 4, 6'h22);          // sub
        m_imem[6]  = enc_r(1, 2, 5, 6'h24);          // and
        m_imem[7]  = enc_r(1, 2, 6, 6'h25);          // or
        m_imem[8]  = enc_r(2, 1, 7, 6'h2A);          // slt -> 1
        m_imem[9]  = enc_r(1, 2, 8, 6'h2A);          // slt -> 0
        m_imem[10] = enc_i(6'h23, 0, 9, 4);          // r9 = 0x80000000
        m_imem[11] = enc_i(6'h23, 0, 10, 8);         // r10 = 0x7FFFFFFF
        m_imem[12] = enc_r(9, 10, 11, 6'h2A);        // overflow case -> 1
        m_imem[13] = enc_r(10, 9, 12, 6'h2A);        // -> 0
        m_imem[14] = enc_i(6'h0A, 9, 13, 0);         // slti negative < 0 -> 1
        m_imem[15] = enc_i(6'h0A, 10, 14, -1);       // large positive < -1 -> 0
        m_imem[16] = enc_i(6'h23, 0, 15, 20);        // r15 = 8
        m_imem[17] = enc_i(6'h2B, 15, 3, -4);        // store r3 at 4
        m_imem[18] = enc_i(6'h23, 0, 16, 4);         // read it back
        m_imem[19] = enc_r(1, 1, 0, 6'h20);          // write to r0 dropped (R9)
        m_imem[20] = enc_r(0, 0, 17, 6'h25);         // r17 = r0|r0 = 0
        m_imem[21] = {6'h00, 5'd1, 5'd1, 5'd18, 5'd0, 6'h3F}; // unknown funct
        m_imem[22] = enc_i(6'h04, 1, 2, 5);          // beq not taken
        m_imem[23] = enc_i(6'h04, 3, 3, 2);          // beq taken -> 26
        m_imem[24] = enc_r(1, 1, 19, 6'h20);
        m_imem[25] = enc_r(1, 1, 19, 6'h20);
        m_imem[26] = enc_i(6'h04, 0, 0, 2);          // unconditional branch -> 29
        m_imem[27] = enc_r(1, 1, 19, 6'h20);
        m_imem[28] = enc_r(1, 1, 19, 6'h20);
        m_imem[29] = enc_j(6'h03, 34);               // jal -> 34, r31 = 120
        m_imem[30] = enc_r(1, 1, 19, 6'h20);
        m_imem[34] = enc_r(31, 0, 20, 6'h20);        // r20 = r31
        m_imem[35] = {6'h3F, 26'd0};                 // undefined opcode
        m_imem[36] = enc_j(6'h02, 40);               // j -> 40
        m_imem[40] = enc_i(6'h04, 0, 0, -1);         // branch to self
        m_dmem[1] = 32'h8000_0000;
        m_dmem[2] = 32'h7FFF_FFFF;
        m_dmem[3] = 32'd5;
        m_dmem[4] = 32'hFFFF_FFFD;
        m_dmem[5] = 32'd8;

        for (int i = 0; i < WORDS; i++) load_word(1'b0, i, m_imem[i]);
        for (int i = 0; i < WORDS; i++) load_word(1'b1, i, m_dmem[i]);
        @(negedge clk);
        load_en = 1'b0;
        @(negedge clk);
        #1;
        // R1: held in reset, nothing commits
        check(pc_o === 32'd0, "R1", "pc in reset", pc_o, 32'd0);
        check(wb_en_o === 1'b0, "R1", "wb_en in reset", {31'd0, wb_en_o}, 32'd0);
        check(st_en_o === 1'b0, "R1", "st_en in reset", {31'd0, st_en_o}, 32'd0);

        m_pc = 32'd0;
        prev_tag = "R1";
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int c = 0; c < RUN_CYCLES; c++) begin
            compare_and_step();
            @(negedge clk);
            #1;
        end

        rst = 1'b1;
        #1;
        check(wb_en_o === 1'b0, "R1", "wb_en on reassert", {31'd0, wb_en_o}, 32'd0);
        @(negedge clk);
        #1;
        check(pc_o === 32'd0, "R1", "pc after reassert", pc_o, 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule